// File: doc/BRIEF.md
# Seeded Random Stall Generator

This block produces a stall strobe for a cryptographic datapath. Stalls inserted at unpredictable cycles break the link between the datapath's timing and the data it is processing, which blunts timing and power side-channel attacks. Software programs a 32-bit seed and a small control word through a simple write port. In internal mode a 32-bit maximal-length LFSR, restarted from the seed, decides in which cycles a stall is raised. A two-bit density field sets how often this happens, from about one cycle in eight to about one in sixty-four.

When internal mode is off, the block forwards an external stall request instead, so the generator can be bypassed by logic elsewhere on the chip. A soft reset input returns every programmable setting to its reset value without touching the chip-level reset.

Top module: `stall_gen_top`

## Requirements
- R1: While `rst_ni` is low, `stall_o` is 0 and internal mode is off. The density field and the seed register reset to 0.
- R2: A write with `wr_addr_i` = 0 updates the control word. Data bit 0 becomes the mode enable. Data bit 1 sets density bit 0 and data bit 2 sets density bit 1. Data bit 3 clears density bit 0 and data bit 4 clears density bit 1. A write with `wr_addr_i` = 1 stores `wr_data_i` as the seed.
- R3: With the enable at 0, `stall_o` equals the value `ext_stall_i` had at the previous rising clock edge.
- R4: With the enable at 1, `ext_stall_i` has no effect. A stall is raised one clock after a cycle in which the lowest Z LFSR bits are all zero. Z is 3, 4, 5 or 6 for density 00, 01, 10 or 11.
- R5: In internal mode `stall_o` is never high in two cycles in a row; a hit in the cycle right after a stall is dropped. The long-run density is therefore one stall in 9, 17, 33 or 65 cycles.
- R6: The LFSR moves forward by a fixed number of shift steps on every clock while the enable is 1. It keeps its state while the enable is 0.
- R7: On the second rising edge after a seed write, the LFSR restarts from the seed. A zero seed is replaced by a fixed nonzero constant, so the LFSR state is never zero.
- R8: The same seed and the same control writes give the same stall sequence. A different seed gives a different sequence.
- R9: Writing 1 to a clear bit clears its density bit. If the set and clear bits for the same density bit are both 1, the clear wins. A 0 in a set or clear bit leaves that density bit unchanged.
- R10: A `soft_rst_i` pulse has the effect of R1 and restarts the LFSR from the zero-seed constant. It wins over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous soft reset of all settings |
| wr_en_i | input | 1 | Write strobe for the register port |
| wr_addr_i | input | 1 | 0 selects the control word, 1 selects the seed |
| wr_data_i | input | 32 | Write data |
| ext_stall_i | input | 1 | External stall request, forwarded when internal mode is off |
| stall_o | output | 1 | Registered stall strobe |

## Verification
A soft reset and a control write can land in the same cycle. The bench drives a soft reset together with a write that turns internal mode on, while `ext_stall_i` is held high. The outcome is judged at the output. Two consecutive high cycles on `stall_o` prove the block forwarded the external request. Internal mode can never produce two highs in a row (R5), so this result shows the soft reset won.

// File: rtl/stall_gen_pkg.sv
package stall_gen_pkg;

    localparam int unsigned LFSR_W        = 32;
    localparam int unsigned RATE_W        = 2;
    localparam int unsigned MIN_ZERO_BITS = 3;
    localparam int unsigned TEST_W        = MIN_ZERO_BITS + (1 << RATE_W) - 1;

    // Galois feedback mask for x^32 + x^22 + x^2 + x + 1 (maximal length)
    localparam logic [LFSR_W-1:0] LFSR_TAPS     = 32'h8020_0003;
    localparam logic [LFSR_W-1:0] LFSR_FALLBACK = 32'h5EED_C0DE;

    // control word layout
    localparam int unsigned CTRL_EN_BIT  = 0;
    localparam int unsigned CTRL_SET_LSB = 1;
    localparam int unsigned CTRL_CLR_LSB = CTRL_SET_LSB + RATE_W;

    typedef enum logic {
        ADDR_CTRL = 1'b0,
        ADDR_SEED = 1'b1
    } wr_addr_e;

    typedef struct packed {
        logic              enable;
        logic [RATE_W-1:0] rate;
        logic [LFSR_W-1:0] seed;
        logic              load;
    } cfg_state_t;

endpackage

// File: rtl/stall_gen_regs.sv
module stall_gen_regs
    import stall_gen_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              soft_rst_i,
    input  logic              wr_en_i,
    input  logic              wr_addr_i,
    input  logic [LFSR_W-1:0] wr_data_i,
    output logic              enable_o,
    output logic [RATE_W-1:0] rate_o,
    output logic [LFSR_W-1:0] seed_o,
    output logic              load_o
);

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.load = 1'b0;
        if (wr_en_i) begin
            if (wr_addr_i == ADDR_SEED) begin
                st_d.seed = wr_data_i;
                st_d.load = 1'b1;
            end else begin
                st_d.enable = wr_data_i[CTRL_EN_BIT];
                for (int i = 0; i < int'(RATE_W); i++) begin
                    if (wr_data_i[CTRL_CLR_LSB + i]) begin
                        st_d.rate[i] = 1'b0;
                    end else if (wr_data_i[CTRL_SET_LSB + i]) begin
                        st_d.rate[i] = 1'b1;
                    end
                end
            end
        end
        if (soft_rst_i) begin
            st_d      = '0;
            st_d.load = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign enable_o = st_q.enable;
    assign rate_o   = st_q.rate;
    assign seed_o   = st_q.seed;
    assign load_o   = st_q.load;

endmodule

// File: rtl/stall_gen_lfsr.sv
module stall_gen_lfsr
    import stall_gen_pkg::*;
#(
    parameter int unsigned STEPS = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [LFSR_W-1:0] seed_i,
    input  logic              advance_i,
    output logic [LFSR_W-1:0] state_o
);

    logic [LFSR_W-1:0] lfsr_d, lfsr_q;
    logic [LFSR_W-1:0] stepped;

    always_comb begin
        stepped = lfsr_q;
        for (int s = 0; s < int'(STEPS); s++) begin
            stepped = stepped[0] ? ((stepped >> 1) ^ LFSR_TAPS) : (stepped >> 1);
        end

        lfsr_d = lfsr_q;
        if (load_i) begin
            lfsr_d = (seed_i == '0) ? LFSR_FALLBACK : seed_i;
        end else if (advance_i) begin
            lfsr_d = stepped;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lfsr_q <= LFSR_FALLBACK;
        end else begin
            lfsr_q <= lfsr_d;
        end
    end

    assign state_o = lfsr_q;

endmodule

// File: rtl/stall_gen_pick.sv
module stall_gen_pick
    import stall_gen_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              soft_rst_i,
    input  logic              enable_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic [TEST_W-1:0] bits_i,
    input  logic              ext_stall_i,
    output logic              stall_o
);

    logic [TEST_W-1:0] mask;
    logic              hit;
    logic              stall_d, stall_q;

    always_comb begin
        for (int i = 0; i < int'(TEST_W); i++) begin
            mask[i] = (i < int'(MIN_ZERO_BITS) + int'(rate_i));
        end
        hit = ((bits_i & mask) == '0);

        if (soft_rst_i) begin
            stall_d = 1'b0;
        end else if (enable_i) begin
            stall_d = hit && !stall_q;
        end else begin
            stall_d = ext_stall_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stall_q <= 1'b0;
        end else begin
            stall_q <= stall_d;
        end
    end

    assign stall_o = stall_q;

endmodule

// File: rtl/stall_gen_top.sv
module stall_gen_top
    import stall_gen_pkg::*;
#(
    parameter int unsigned STEPS_PER_CLK = 8
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        soft_rst_i,
    input  logic        wr_en_i,
    input  logic        wr_addr_i,
    input  logic [31:0] wr_data_i,
    input  logic        ext_stall_i,
    output logic        stall_o
);

    logic              cfg_en;
    logic [RATE_W-1:0] cfg_rate;
    logic [LFSR_W-1:0] cfg_seed;
    logic              seed_load;
    logic [LFSR_W-1:0] lfsr_state;

    stall_gen_regs u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .soft_rst_i (soft_rst_i),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .enable_o   (cfg_en),
        .rate_o     (cfg_rate),
        .seed_o     (cfg_seed),
        .load_o     (seed_load)
    );

    stall_gen_lfsr #(
        .STEPS (STEPS_PER_CLK)
    ) u_lfsr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (seed_load),
        .seed_i    (cfg_seed),
        .advance_i (cfg_en),
        .state_o   (lfsr_state)
    );

    stall_gen_pick u_pick (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .soft_rst_i  (soft_rst_i),
        .enable_i    (cfg_en),
        .rate_i      (cfg_rate),
        .bits_i      (lfsr_state[TEST_W-1:0]),
        .ext_stall_i (ext_stall_i),
        .stall_o     (stall_o)
    );

endmodule

// File: rtl/stall_gen_chk.sv
module stall_gen_chk
    import stall_gen_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              soft_rst_i,
    input logic              wr_en_i,
    input logic              wr_addr_i,
    input logic [LFSR_W-1:0] wr_data_i,
    input logic              ext_stall_i,
    input logic              stall_o,
    input logic              en_i,
    input logic [RATE_W-1:0] rate_i,
    input logic [LFSR_W-1:0] seed_i,
    input logic              load_i,
    input logic [LFSR_W-1:0] lfsr_i
);

    always @(negedge clk_i) begin
        if (rst_ni === 1'b0) begin
            assert_reset_R1: assert (stall_o == 1'b0 && en_i == 1'b0 && rate_i == '0 && seed_i == '0);
        end
    end

    assert_passthru_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_i && !soft_rst_i) |=> (stall_o == $past(ext_stall_i)));

    assert_guard_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && stall_o && !soft_rst_i) |=> !stall_o);

    assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_i && !load_i) |=> $stable(lfsr_i));

    assert_advance_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !load_i) |=> (lfsr_i != $past(lfsr_i)));

    assert_nonzero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lfsr_i != '0);

    assert_seedload_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (lfsr_i == (($past(seed_i) == '0) ? LFSR_FALLBACK : $past(seed_i))));

    assert_clear_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == ADDR_CTRL && wr_data_i[CTRL_CLR_LSB] && !soft_rst_i)
        |=> !rate_i[0]);

    assert_soft_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        soft_rst_i |=> (!en_i && rate_i == '0 && !stall_o && load_i));

endmodule

bind stall_gen_top stall_gen_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .soft_rst_i  (soft_rst_i),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .ext_stall_i (ext_stall_i),
    .stall_o     (stall_o),
    .en_i        (cfg_en),
    .rate_i      (cfg_rate),
    .seed_i      (cfg_seed),
    .load_i      (seed_load),
    .lfsr_i      (lfsr_state)
);

// File: tb/sim_stall_gen_top.sv
module sim_stall_gen_top;

    localparam int NREC    = 256;
    localparam int NDENS   = 16384;
    localparam int NVEC    = 6;
    localparam int WDOG    = 190000;
    localparam logic [31:0] SEED_A = 32'h1234_ABCD;
    localparam logic [31:0] SEED_B = 32'h0BAD_F00D;

    // control word + expected stall period (guard cycle adds one)
    localparam logic [4:0] VEC_CTRL [0:NVEC-1] = '{5'b00001, 5'b00011, 5'b00101,
                                                   5'b01001, 5'b11001, 5'b11111};
    localparam int         VEC_DIV  [0:NVEC-1] = '{9, 17, 65, 33, 9, 9};

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b1;
    logic        soft_rst_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic        wr_addr_i = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic        ext_stall_i = 1'b0;
    logic        stall_o;

    int n_checks = 0;
    int n_fail   = 0;

    logic [NREC-1:0] seq_a, seq_b, seq_c, seq_d, seq_f, seq_g;

    always #10 clk_i = ~clk_i;

    stall_gen_top u0 (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .soft_rst_i  (soft_rst_i),
        .wr_en_i     (wr_en_i),
        .wr_addr_i   (wr_addr_i),
        .wr_data_i   (wr_data_i),
        .ext_stall_i (ext_stall_i),
        .stall_o     (stall_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic addr, input logic [31:0] data);
        @(negedge clk_i);
        wr_en_i   = 1'b1;
        wr_addr_i = addr;
        wr_data_i = data;
        @(negedge clk_i);
        wr_en_i   = 1'b0;
        wr_data_i = '0;
    endtask

    task automatic record(output logic [NREC-1:0] seq);
        seq = '0;
        for (int i = 0; i < NREC; i++) begin
            @(negedge clk_i);
            seq[i] = stall_o;
        end
    endtask

    // disable with ext low, load seed, enable rate 00, record
    task automatic seeded_run(input logic [31:0] seed, input int idle, output logic [NREC-1:0] seq);
        ext_stall_i = 1'b0;
        wr(1'b0, 32'h0);
        wr(1'b1, seed);
        repeat (idle) @(negedge clk_i);
        wr(1'b0, 32'h1 | 32'h18);
        record(seq);
    endtask

    initial begin
        repeat (WDOG) @(posedge clk_i);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", WDOG, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1 rst_ni = 1'b0;
        repeat (3) @(negedge clk_i);
        check(stall_o == 1'b0, "R1 stall low in reset", longint'(stall_o), 0);
        ext_stall_i = 1'b1;
        @(negedge clk_i);
        check(stall_o == 1'b0, "R1 reset overrides ext", longint'(stall_o), 0);
        rst_ni = 1'b1;

        // R3: pass-through after reset (enable resets to 0)
        begin
            logic pat [0:5] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
            for (int i = 0; i < 6; i++) begin
                ext_stall_i = pat[i];
                @(negedge clk_i);
                check(stall_o == pat[i], "R3 pass-through", longint'(stall_o), longint'(pat[i]));
            end
        end

        // R4/R5/R2/R9: density table, ext held high to show it is ignored
        wr(1'b1, SEED_A);
        ext_stall_i = 1'b1;
        for (int v = 0; v < NVEC; v++) begin
            int cnt;
            int exp_cnt;
            wr(1'b0, {27'h0, VEC_CTRL[v]});
            repeat (2) @(negedge clk_i);
            cnt = 0;
            for (int c = 0; c < NDENS; c++) begin
                @(negedge clk_i);
                if (stall_o) cnt++;
            end
            exp_cnt = NDENS / VEC_DIV[v];
            check((cnt * 4 > exp_cnt * 3) && (cnt * 4 < exp_cnt * 5),
                  "R4 R5 R2 R9 stall density", cnt, exp_cnt);
        end
        ext_stall_i = 1'b0;

        // R8: reproducibility
        seeded_run(SEED_A, 0, seq_a);
        seeded_run(SEED_A, 0, seq_b);
        check(seq_a == seq_b, "R8 same seed repeats", longint'($countones(seq_a ^ seq_b)), 0);
        check(seq_a != '0, "R4 stalls present", longint'($countones(seq_a)), 1);
        seeded_run(SEED_B, 0, seq_d);
        check(seq_a != seq_d, "R8 other seed differs", 0, 1);

        // R6: idling while disabled must not move the LFSR
        seeded_run(SEED_A, 40, seq_c);
        check(seq_a == seq_c, "R6 hold while disabled", longint'($countones(seq_a ^ seq_c)), 0);

        // R7: zero seed still runs; R10: soft reset reloads the same constant
        seeded_run(32'h0, 0, seq_f);
        check(seq_f != '0, "R7 zero seed not stuck", longint'($countones(seq_f)), 1);
        @(negedge clk_i);
        soft_rst_i = 1'b1;
        @(negedge clk_i);
        soft_rst_i = 1'b0;
        wr(1'b0, 32'h1);
        record(seq_g);
        check(seq_f == seq_g, "R10 soft reset restarts from zero seed",
              longint'($countones(seq_f ^ seq_g)), 0);

        // R10: soft reset and enabling write in the same cycle
        @(negedge clk_i);
        ext_stall_i = 1'b1;
        soft_rst_i  = 1'b1;
        wr_en_i     = 1'b1;
        wr_addr_i   = 1'b0;
        wr_data_i   = 32'h1;
        @(negedge clk_i);
        soft_rst_i  = 1'b0;
        wr_en_i     = 1'b0;
        wr_data_i   = '0;
        check(stall_o == 1'b0, "R10 stall cleared by soft reset", longint'(stall_o), 0);
        @(negedge clk_i);
        check(stall_o == 1'b1, "R10 soft reset wins first", longint'(stall_o), 1);
        @(negedge clk_i);
        check(stall_o == 1'b1, "R10 soft reset wins second", longint'(stall_o), 1);
        ext_stall_i = 1'b0;
        @(negedge clk_i);
        check(stall_o == 1'b0, "R3 pass-through low", longint'(stall_o), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule